// File: doc/BRIEF.md
# Fractional Clock Divider with Source Switch

This block makes a slower clock from one of two reference clocks: an on-chip oscillator clock or a clock brought in from a pin. A select input picks the source. A 5-bit code sets the divide ratio. Every integer ratio from 1 to 16 is available, along with two half-integer ratios, 1.5 and 2.5. Integer ratios give an exact 50% duty cycle, odd ones included. To get there, the output is built from two phase registers: one is loaded on the falling edge of the selected clock and drives the output while that clock is high, and the other is loaded on the rising edge and drives the output while the clock is low.

Changes to the divide code and the source select never take effect in the middle of an output pattern. The block samples both on the falling edge that closes the last input cycle of the current pattern, and applies them on the next rising edge. The source change then runs through a handshake. Each source has its own enable flops, and a source is enabled only after the other source has dropped its enable on its own falling edge. Reset is synchronous and active high, and it holds the output low.

Top module: `ckd_frac_div`

## Requirements
- R1: With `src_sel` = 0 the output is derived from `osc_clk`. With `src_sel` = 1 it is derived from `ext_clk`. Every output transition lines up with an edge of the selected clock.
- R2: A code `div_code` = N, with N from 1 to 16, gives an output period of N selected-clock periods. The output is high for the first N half-periods of each period and low for the next N, so the duty cycle is 50% for odd N too.
- R3: Code 1 passes the selected clock through: the output is high while that clock is high and low while it is low.
- R4: Code 17 divides by 1.5. Each output period is 3 half-periods of the selected clock, high for the first 2 and low for the last 1.
- R5: Code 18 divides by 2.5. Each output period is 5 half-periods, high for the first 3 and low for the last 2.
- R6: Any other code (0 and 19 to 31) holds the output low.
- R7: The output repeats a pattern of L input cycles, where L is N for codes 1 to 16, 3 for code 17, 5 for code 18 and 1 for invalid codes. `div_code` is sampled only on the falling edge that ends the last cycle of a pattern. The new pattern starts at its first half-period on the next rising edge, and a code change at any other time has no effect on the output until then.
- R8: `src_sel` is captured at the same pattern boundary as the code. The two source enables are never on together. During a switch the output shows no pulse shorter than the shorter half-period of the output before or after the switch. Once the switch is complete, the output follows the newly selected clock.
- R9: While `rst` is high the output stays low, and `src_sel` chooses the clock that runs the block. `src_sel` must be held stable during reset. After `rst` falls, the output stays low until the first falling edge of the selected clock, and the new pattern starts on the rising edge that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | On-chip oscillator clock |
| ext_clk | input | 1 | Clock from the external pin |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Source select: 0 oscillator, 1 external |
| div_code | input | 5 | Divide code: 1-16 integer, 17 = 1.5, 18 = 2.5, others = off |
| div_clk | output | 1 | Divided clock |

## Verification
Some properties are checked on every cycle of the selected clock. The two source enables are never on together. The active code changes only when the cycle counter has just returned to the start of a pattern. An invalid code leaves the low-phase register cleared. Ratio 1 keeps the high-phase register set and the low-phase register clear. Other behaviour can only be shown by the bench scenarios: the exact half-period shapes of each ratio, the duty cycle of odd ratios, a code change being deferred to the pattern boundary, the first rising edge after reset, and the absence of short pulses while the source switches.

// File: rtl/ckd_pkg.sv
`timescale 1ns/100ps
package ckd_pkg;

    parameter int unsigned CODE_W  = 5;
    parameter int unsigned MAX_DIV = 16;

    localparam int unsigned CODE_H15  = MAX_DIV + 1;
    localparam int unsigned CODE_H25  = MAX_DIV + 2;
    localparam int unsigned MAX_CYC   = (MAX_DIV > 5) ? MAX_DIV : 5;
    localparam int unsigned CNT_W     = $clog2(MAX_CYC);
    localparam int unsigned NUM_SRC   = 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_EXT = 1'b1
    } src_e;

    typedef struct packed {
        logic hi;   // drives the output while the selected clock is high
        logic lo;   // drives the output while the selected clock is low
    } phase_t;

    // Output period in half-periods of the selected clock; 0 marks an off code.
    function automatic int unsigned period_halves(code_t c);
        int unsigned v = 32'(c);
        if (v >= 1 && v <= MAX_DIV) return 2 * v;
        if (v == CODE_H15)          return 3;
        if (v == CODE_H25)          return 5;
        return 0;
    endfunction

    // Number of half-periods the output spends high within one period.
    function automatic int unsigned high_halves(code_t c);
        int unsigned v = 32'(c);
        if (v >= 1 && v <= MAX_DIV) return v;
        if (v == CODE_H15)          return 2;
        if (v == CODE_H25)          return 3;
        return 0;
    endfunction

    function automatic logic code_valid(code_t c);
        return period_halves(c) != 0;
    endfunction

    // Input cycles until the half-period pattern repeats.
    function automatic int unsigned pattern_cycles(code_t c);
        int unsigned p = period_halves(c);
        if (p == 0)     return 1;
        if (p % 2 == 0) return p / 2;
        return p;
    endfunction

    // Output level for half-period (2*idx + low_half) of the pattern.
    function automatic logic phase_level(code_t c, int unsigned idx, logic low_half);
        int unsigned p = period_halves(c);
        int unsigned h;
        if (p == 0) return 1'b0;
        h = 2 * idx + (low_half ? 1 : 0);
        return (h % p) < high_halves(c);
    endfunction

endpackage

// File: rtl/ckd_src_switch.sv
`timescale 1ns/100ps
module ckd_src_switch
    import ckd_pkg::*;
(
    input  logic osc_clk,
    input  logic ext_clk,
    input  logic rst,
    input  src_e req_sel,    // selection applied at a pattern boundary
    input  src_e rst_sel,    // selection used while reset is high
    output logic mclk
);

    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] on_q;

    assign src_clk = {ext_clk, osc_clk};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_leg
        logic want;
        logic arm_q;
        logic on_r;

        // Ask for this source only once the other leg has let go.
        assign want = rst ? (32'(rst_sel) == g)
                          : ((32'(req_sel) == g) && !on_q[1-g]);

        always_ff @(posedge src_clk[g]) begin
            arm_q <= want;
        end

        // Enable changes only while this source is low.
        always_ff @(negedge src_clk[g]) begin
            on_r <= arm_q;
        end

        assign on_q[g] = on_r;
    end

    assign mclk = |(src_clk & on_q);

    always_comb begin
        if (!rst) begin
            p_single_source_r8: assert ($onehot0(on_q))
                else $error("both clock sources enabled");
        end
    end

endmodule

// File: rtl/ckd_phase_gen.sv
`timescale 1ns/100ps
module ckd_phase_gen
    import ckd_pkg::*;
(
    input  logic   mclk,
    input  logic   rst,
    input  code_t  code_in,
    input  src_e   src_in,
    output src_e   src_q,
    output phase_t ph
);

    code_t       cur_q;
    code_t       pend_q;
    cnt_t        cnt_q;
    logic        bnd_q;
    src_e        src_pend_q;
    logic        hi_q;
    logic        lo_q;
    logic        last_cyc;
    int unsigned nxt_idx;

    always_comb begin
        last_cyc = (32'(cnt_q) + 1) >= pattern_cycles(cur_q);
        nxt_idx  = 32'(cnt_q) + 1;
    end

    // Falling edge: sample settings at the pattern end, prepare next high phase.
    always_ff @(negedge mclk) begin
        if (rst) begin
            bnd_q      <= 1'b0;
            pend_q     <= '0;
            src_pend_q <= src_in;
            hi_q       <= 1'b0;
        end else begin
            bnd_q <= last_cyc;
            if (last_cyc) begin
                pend_q     <= code_in;
                src_pend_q <= src_in;
                hi_q       <= phase_level(code_in, 0, 1'b0);
            end else begin
                hi_q <= phase_level(cur_q, nxt_idx, 1'b0);
            end
        end
    end

    // Rising edge: advance the cycle count, prepare the coming low phase.
    always_ff @(posedge mclk) begin
        if (rst) begin
            cur_q <= '0;
            cnt_q <= '0;
            lo_q  <= 1'b0;
            src_q <= src_in;
        end else if (bnd_q) begin
            cur_q <= pend_q;
            cnt_q <= '0;
            src_q <= src_pend_q;
            lo_q  <= phase_level(pend_q, 0, 1'b1);
        end else begin
            cnt_q <= cnt_q + 1'b1;
            lo_q  <= phase_level(cur_q, nxt_idx, 1'b1);
        end
    end

    assign ph = '{hi: hi_q, lo: lo_q};

    p_load_at_start_r7: assert property (@(posedge mclk) disable iff (rst)
        !$stable(cur_q) |-> (cnt_q == '0))
        else $error("active code changed away from a pattern start");

    p_off_code_low_r6: assert property (@(posedge mclk) disable iff (rst)
        !code_valid(cur_q) |-> !lo_q)
        else $error("low phase set under an off code");

    p_bypass_r3: assert property (@(posedge mclk) disable iff (rst)
        ((32'(cur_q) == 1) && (32'(pend_q) == 1)) |-> (hi_q && !lo_q))
        else $error("ratio 1 phases wrong");

endmodule

// File: rtl/ckd_frac_div.sv
`timescale 1ns/100ps
module ckd_frac_div
    import ckd_pkg::*;
(
    input  logic              osc_clk,
    input  logic              ext_clk,
    input  logic              rst,
    input  logic              src_sel,
    input  logic [CODE_W-1:0] div_code,
    output logic              div_clk
);

    src_e   sel_raw;
    src_e   sel_applied;
    phase_t ph;
    logic   mclk;

    assign sel_raw = src_e'(src_sel);

    ckd_src_switch u_switch (
        .osc_clk (osc_clk),
        .ext_clk (ext_clk),
        .rst     (rst),
        .req_sel (sel_applied),
        .rst_sel (sel_raw),
        .mclk    (mclk)
    );

    ckd_phase_gen u_phase (
        .mclk    (mclk),
        .rst     (rst),
        .code_in (code_t'(div_code)),
        .src_in  (sel_raw),
        .src_q   (sel_applied),
        .ph      (ph)
    );

    // Each phase register is stable for the whole half it drives.
    assign div_clk = mclk ? ph.hi : ph.lo;

endmodule

// File: tb/ckd_frac_div_tb_top.sv
`timescale 1ns/100ps
module ckd_frac_div_tb_top;

    logic       osc_clk  = 1'b0;
    logic       ext_clk  = 1'b0;
    logic       rst      = 1'b1;
    logic       src_sel  = 1'b0;
    logic [4:0] div_code = 5'd0;
    logic       div_clk;

    int checks = 0;
    int errors = 0;

    // reference model state, counted in half-periods of the selected clock
    int m_cur  = 0;
    int m_pend = 0;
    int m_h    = 1;

    // pulse-width monitor
    real last_edge = 0.0;
    real min_w     = 1.0e9;
    bit  mon_on    = 1'b0;

    ckd_frac_div dut_i (
        .osc_clk  (osc_clk),
        .ext_clk  (ext_clk),
        .rst      (rst),
        .src_sel  (src_sel),
        .div_code (div_code),
        .div_clk  (div_clk)
    );

    // 125 MHz bench clock doubles as the external source
    always #4 ext_clk = ~ext_clk;

    initial begin
        #0.5;
        forever #7 osc_clk = ~osc_clk;
    end

    always @(div_clk) begin
        if (mon_on && (($realtime - last_edge) < min_w)) min_w = $realtime - last_edge;
        last_edge = $realtime;
    end

    function automatic int m_per(int c);
        if (c >= 1 && c <= 16) return 2 * c;
        case (c)
            17: return 3;
            18: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic int m_high(int c);
        if (c >= 1 && c <= 16) return c;
        case (c)
            17: return 2;
            18: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int m_len(int c);
        int p = m_per(c);
        if (p == 0) return 1;
        return (p % 2 == 0) ? p / 2 : p;
    endfunction

    function automatic logic m_exp(int c, int h);
        int p = m_per(c);
        if (p == 0) return 1'b0;
        return (h % p) < m_high(c);
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk_bit(logic act, logic exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: div_clk=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_real(real act, real exp, string req);
        checks++;
        if (act < exp - 0.05 || act > exp + 0.05) begin
            errors++;
            $display("FAIL %s: measured %0.2f expected %0.2f", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        if (src_sel) @(posedge ext_clk);
        else         @(posedge osc_clk);
    endtask

    task automatic wait_fall();
        if (src_sel) @(negedge ext_clk);
        else         @(negedge osc_clk);
    endtask

    task automatic do_reset(logic src, int code);
        rst      = 1'b1;
        src_sel  = src;
        div_code = 5'(code);
        repeat (30) @(posedge ext_clk);
        for (int i = 0; i < 3; i++) begin
            @(posedge ext_clk);
            #2;
            chk_bit(div_clk, 1'b0, "R9 output low in reset");
        end
        wait_rise();
        #2;
        rst    = 1'b0;
        m_cur  = 0;
        m_pend = 0;
        m_h    = 1;
    endtask

    task automatic run_halves(int n, string req);
        for (int i = 0; i < n; i++) begin
            if (m_h % 2 == 0) begin
                wait_rise();
                if (m_h >= 2 * m_len(m_cur)) begin
                    m_cur = m_pend;
                    m_h   = 0;
                end
            end else begin
                wait_fall();
                if (m_h == 2 * m_len(m_cur) - 1) m_pend = int'(div_code);
            end
            #2;
            chk_bit(div_clk, m_exp(m_cur, m_h), req);
            m_h++;
        end
    endtask

    task automatic measure(real hi_exp, real per_exp, string req);
        real t0, t1, t2;
        @(posedge div_clk);
        t0 = $realtime;
        @(negedge div_clk);
        t1 = $realtime;
        @(posedge div_clk);
        t2 = $realtime;
        chk_real(t1 - t0, hi_exp, req);
        chk_real(t2 - t0, per_exp, req);
    endtask

    initial begin
        #900000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R9 and R1: first pattern on the oscillator, even ratio
        do_reset(1'b0, 4);
        run_halves(2, "R9 first rise after release");
        run_halves(30, "R2 R1 divide by 4 on osc");

        // odd ratio on the external clock
        do_reset(1'b1, 5);
        run_halves(44, "R2 R1 divide by 5 on ext");

        do_reset(1'b1, 1);
        run_halves(16, "R3 pass-through");

        do_reset(1'b0, 16);
        run_halves(70, "R2 divide by 16");

        do_reset(1'b0, 7);
        run_halves(32, "R2 divide by 7 on osc");

        do_reset(1'b1, 17);
        run_halves(24, "R4 divide by 1.5");

        do_reset(1'b0, 18);
        run_halves(26, "R5 divide by 2.5");

        // off codes, then a valid one again
        do_reset(1'b1, 0);
        run_halves(10, "R6 code 0");
        div_code = 5'd25;
        run_halves(10, "R6 code 25");
        div_code = 5'd31;
        run_halves(10, "R6 code 31");
        div_code = 5'd19;
        run_halves(10, "R6 code 19");
        div_code = 5'd2;
        run_halves(12, "R7 leave off code");

        // code changes mid-pattern wait for the boundary
        do_reset(1'b1, 8);
        run_halves(9, "R7 before change");
        div_code = 5'd3;
        run_halves(40, "R7 8 to 3 deferred");
        run_halves(3, "R7 settle");
        div_code = 5'd17;
        run_halves(20, "R7 3 to 1.5 deferred");
        div_code = 5'd18;
        run_halves(30, "R7 1.5 to 2.5 deferred");

        // source switch, oscillator to external, ratio 2
        do_reset(1'b0, 2);
        run_halves(12, "R8 before switch");
        min_w  = 1.0e9;
        mon_on = 1'b1;
        src_sel = 1'b1;
        repeat (20) @(posedge ext_clk);
        mon_on = 1'b0;
        chk_real((min_w >= 7.95) ? 8.0 : min_w, 8.0, "R8 no short pulse osc to ext");
        measure(8.0, 16.0, "R8 R1 follows ext after switch");

        // external back to oscillator with ratio 3
        #2;
        min_w    = 1.0e9;
        mon_on   = 1'b1;
        div_code = 5'd3;
        src_sel  = 1'b0;
        repeat (40) @(posedge ext_clk);
        mon_on = 1'b0;
        chk_real((min_w >= 7.95) ? 8.0 : min_w, 8.0, "R8 no short pulse ext to osc");
        measure(21.0, 42.0, "R8 R2 follows osc after switch");

        finish_run();
    end

endmodule